// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block sits in an interrupt distributor and turns one register write into inter-processor interrupts. A CPU writes a 32-bit command word to a write-only register. The write also carries the ID of the CPU that issued it. The block decodes three things from the word:

- which of 16 software interrupt IDs to raise;
- a bitmap of target CPUs;
- a filter mode that says how the targets are chosen.

It then sets that interrupt's pending bit on every selected CPU. Each selected CPU other than the writer also gets a one-cycle kick, which tells it to look at its pending interrupts again.

Each CPU has a clear port. A CPU uses it to remove a pending software interrupt once it has taken it. Priority arbitration and acknowledge handshakes live outside this block. The block holds only the pending state and the kick fan-out.

Top module: `sgi_dispatch`

## Requirements
- R1: After a synchronous active-low reset, every pending bit (`pend_o`) and every kick line (`kick_o`) is 0.
- R2: A write with `wr_en_i`=1 and `wr_addr_i`=0xF00 takes the interrupt ID from data bits 3:0 and the filter from bits 25:24. Filter 0 selects the CPUs whose bit is set in data bits 23:16, where bit 16+n selects CPU n. For each selected CPU n, bit n*16+ID of `pend_o` reads 1 from the cycle after the write's clock edge.
- R3: Filter 1 selects every CPU except the one named on `wr_cpu_i`, whatever the target bitmap holds.
- R4: Filter 2 selects only the CPU named on `wr_cpu_i`, whatever the target bitmap holds.
- R5: Filter 3 is reserved. It sets no pending bit and raises no kick.
- R6: Target bitmap bits for CPU numbers at or above the number of CPUs (data bits 23:20 with four CPUs) select nothing. Data bits 15:4 and 31:26 have no effect.
- R7: For each selected CPU other than the writer, `kick_o[n]` is 1 for exactly the cycle after the write. The writer never gets a kick, even when it is a target. Kicks drop back to 0 in the next cycle unless another write kicks again.
- R8: Raising an interrupt that is already pending on a target leaves that bit set and leaves all other bits unchanged. The kick to non-writer targets is still sent.
- R9: `clr_en_i[n]`=1 with ID `clr_id_i[n*4+3:n*4]` clears bit n*16+ID of `pend_o` from the next cycle and touches no other bit.
- R10: A clear and a set of the same CPU and ID in the same cycle leave the bit set.
- R11: A write to any address other than 0xF00, or a cycle with `wr_en_i`=0, changes neither `pend_o` nor `kick_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Distributor byte offset of the write |
| wr_data_i | input | 32 | Command word: ID, target bitmap, filter |
| wr_cpu_i | input | 2 | ID of the CPU issuing the write |
| clr_en_i | input | 4 | Per-CPU clear strobe |
| clr_id_i | input | 16 | Per-CPU interrupt ID to clear, 4 bits per CPU |
| pend_o | output | 64 | Pending bits, CPU n at bits n*16+15:n*16 |
| kick_o | output | 4 | One-cycle re-evaluation pulse per CPU |

## Verification
The assertions check the following on every cycle:

- a set always wins over a same-cycle clear;
- a pending bit never rises without a set;
- a clear takes effect;
- the writer never kicks itself;
- the self-only and reserved filters raise no kick;
- a write outside the register offset leaves the pending state untouched.

Other behaviours need the bench's scenarios to show them. These are the exact set of CPUs each filter mode selects, that target bits above the last CPU are ignored, that a repeated raise is idempotent while the kick is still sent, and that the kick is a single-cycle pulse.

// File: rtl/sgi_pkg.sv
// Package: shared field positions and filter encoding for the
// software-generated interrupt dispatcher.
// Assumes a 32-bit command word with fixed field positions.
package sgi_pkg;

    localparam int unsigned SGI_WORD_W   = 32;
    localparam int unsigned SGI_ID_LSB   = 0;
    localparam int unsigned SGI_LIST_LSB = 16;
    localparam int unsigned SGI_LIST_W   = 8;
    localparam int unsigned SGI_FLT_LSB  = 24;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;

endpackage

// File: rtl/sgi_cmd_decode.sv
// Module: sgi_cmd_decode
// Decodes one command write into an interrupt ID, a mask of target CPUs
// and a mask of CPUs to kick (targets other than the writer).
// Purely combinational. Assumes NUM_CPU <= 8 and NUM_SGI <= 16, so the
// target bitmap and ID fields fit the command word.
module sgi_cmd_decode
    import sgi_pkg::*;
#(
    parameter int unsigned NUM_CPU    = 4,
    parameter int unsigned NUM_SGI    = 16,
    parameter int unsigned ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hF00,
    localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned ID_W      = $clog2(NUM_SGI)
) (
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [SGI_WORD_W-1:0] wr_data_i,
    input  logic [CPU_W-1:0]      wr_cpu_i,
    output logic                  hit_o,
    output logic [ID_W-1:0]       id_o,
    output logic [NUM_CPU-1:0]    target_o,
    output logic [NUM_CPU-1:0]    kick_o
);

    logic [NUM_CPU-1:0] self_oh;
    logic [NUM_CPU-1:0] list_bits;
    logic [NUM_CPU-1:0] sel;
    sgi_filter_e        filter;
    logic               unused_data;

    // Fold the whole word so bits without a field are consumed.
    assign unused_data = ^wr_data_i;

    assign hit_o     = wr_en_i && (wr_addr_i == REG_OFFSET);
    assign id_o      = wr_data_i[SGI_ID_LSB +: ID_W];
    assign list_bits = wr_data_i[SGI_LIST_LSB +: NUM_CPU];
    assign filter    = sgi_filter_e'(wr_data_i[SGI_FLT_LSB +: 2]);

    // One-hot mask of the writing CPU.
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            self_oh[c] = (wr_cpu_i == CPU_W'(c));
        end
    end

    // Choose the target set for the filter mode.
    always_comb begin
        unique case (filter)
            FLT_LIST:   sel = list_bits;
            FLT_OTHERS: sel = ~self_oh;
            FLT_SELF:   sel = self_oh;
            default:    sel = '0;
        endcase
    end

    assign target_o = hit_o ? sel : '0;
    assign kick_o   = target_o & ~self_oh;

endmodule

// File: rtl/sgi_pend_bank.sv
// Module: sgi_pend_bank
// Pending state of the software interrupts for one CPU. A set request
// and a clear request may arrive in the same cycle; a set wins on the
// same bit. Synchronous active-low reset clears all bits.
module sgi_pend_bank #(
    parameter int unsigned NUM_SGI = 16,
    localparam int unsigned ID_W   = $clog2(NUM_SGI)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en_i,
    input  logic [ID_W-1:0]    set_id_i,
    input  logic               clr_en_i,
    input  logic [ID_W-1:0]    clr_id_i,
    output logic [NUM_SGI-1:0] pend_o
);

    logic [NUM_SGI-1:0] pend_q;
    logic [NUM_SGI-1:0] set_vec;
    logic [NUM_SGI-1:0] clr_vec;

    // Expand the requests into per-bit masks.
    always_comb begin
        set_vec = set_en_i ? (NUM_SGI'(1) << set_id_i) : '0;
        clr_vec = clr_en_i ? (NUM_SGI'(1) << clr_id_i) : '0;
    end

    // Update the pending bits; a set is applied after the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    assign pend_o = pend_q;

    // R10: a raised interrupt is pending next cycle, even when cleared at the same time.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> pend_q[$past(set_id_i)]);

    // R9: a clear not paired with a set of the same ID removes the bit.
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !(set_en_i && set_id_i == clr_id_i)) |=> !pend_q[$past(clr_id_i)]);

    // R8: no pending bit rises without a set request.
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en_i |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/sgi_kick_gen.sv
// Module: sgi_kick_gen
// Registers the per-CPU kick mask so that each kick is a one-cycle pulse
// in the cycle after the write. Synchronous active-low reset.
module sgi_kick_gen #(
    parameter int unsigned NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] kick_mask_i,
    output logic [NUM_CPU-1:0] kick_o
);

    logic [NUM_CPU-1:0] kick_q;

    // Capture this cycle's kick mask; it lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) kick_q <= '0;
        else        kick_q <= kick_mask_i;
    end

    assign kick_o = kick_q;

endmodule

// File: rtl/sgi_dispatch.sv
// Module: sgi_dispatch (top)
// Write-only command register that raises software interrupts on a set
// of CPUs and kicks each target other than the writer. One bank of
// pending bits per CPU, each with its own clear port.
// Assumes the writer ID on wr_cpu_i is valid whenever wr_en_i is high.
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned NUM_SGI = 16,
    parameter int unsigned ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hF00,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned ID_W   = $clog2(NUM_SGI)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [SGI_WORD_W-1:0]      wr_data_i,
    input  logic [CPU_W-1:0]           wr_cpu_i,
    input  logic [NUM_CPU-1:0]         clr_en_i,
    input  logic [NUM_CPU*ID_W-1:0]    clr_id_i,
    output logic [NUM_CPU*NUM_SGI-1:0] pend_o,
    output logic [NUM_CPU-1:0]         kick_o
);

    logic               hit;
    logic [ID_W-1:0]    sgi_id;
    logic [NUM_CPU-1:0] target;
    logic [NUM_CPU-1:0] kick_mask;

    sgi_cmd_decode #(
        .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI),
        .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
    ) u_decode (
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .wr_cpu_i (wr_cpu_i),
        .hit_o    (hit),
        .id_o     (sgi_id),
        .target_o (target),
        .kick_o   (kick_mask)
    );

    // One pending bank per CPU.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        sgi_pend_bank #(.NUM_SGI(NUM_SGI)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en_i(target[c]),
            .set_id_i(sgi_id),
            .clr_en_i(clr_en_i[c]),
            .clr_id_i(clr_id_i[c*ID_W +: ID_W]),
            .pend_o  (pend_o[c*NUM_SGI +: NUM_SGI])
        );
    end

    sgi_kick_gen #(.NUM_CPU(NUM_CPU)) u_kick (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_mask_i(kick_mask),
        .kick_o     (kick_o)
    );

    // R7: the writer never receives a kick for its own write.
    a_r7_no_self_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !$isunknown(wr_cpu_i)) |=> !kick_o[$past(wr_cpu_i)]);

    // R4: the self-only filter kicks nobody.
    a_r4_self_no_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data_i[SGI_FLT_LSB +: 2] == 2'd2) |=> (kick_o == '0));

    // R5: the reserved filter kicks nobody.
    a_r5_rsvd_no_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data_i[SGI_FLT_LSB +: 2] == 2'd3) |=> (kick_o == '0));

    // R11: without a register hit and without clears, pending state holds.
    a_r11_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && clr_en_i == '0) |=> $stable(pend_o));

endmodule

// File: tb/sgi_dispatch_bench.sv
// Scoreboard bench: the driver task applies one cycle of stimulus, updates
// a reference model and queues the expected outputs; a monitor pops and
// compares them at the falling edge after the capturing rising edge.
module sgi_dispatch_bench;

    localparam int NC = 4;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    wr_cpu = '0;
    logic [NC-1:0] clr_en = '0;
    logic [NC*4-1:0] clr_id = '0;
    logic [NC*NS-1:0] pend;
    logic [NC-1:0] kick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [NC*NS-1:0] pend;
        logic [NC-1:0]    kick;
        string            tag;
    } exp_t;

    exp_t sb[$];
    logic [NC*NS-1:0] model = '0;

    always #5 clk = ~clk;

    sgi_dispatch u_sgi_dispatch (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_cpu_i(wr_cpu),
        .clr_en_i(clr_en), .clr_id_i(clr_id),
        .pend_o(pend), .kick_o(kick)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare queued expectations.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check({it.tag, " pend"}, 64'(pend), 64'(it.pend));
            check({it.tag, " kick"}, 64'(kick), 64'(it.kick));
        end
    end

    // Driver: one cycle of stimulus plus expected result.
    task automatic op(input logic we, input logic [11:0] addr, input logic [31:0] data,
                      input logic [1:0] cpu, input logic [NC-1:0] ce,
                      input logic [NC*4-1:0] cid, input string tag);
        logic [NC*NS-1:0] setm;
        logic [NC-1:0]    ke;
        exp_t it;
        @(negedge clk);
        wr_en = we; wr_addr = addr; wr_data = data; wr_cpu = cpu;
        clr_en = ce; clr_id = cid;
        setm = '0; ke = '0;
        if (we && addr == 12'hF00) begin
            for (int c = 0; c < NC; c++) begin
                bit sel;
                case (data[25:24])
                    2'd0: sel = data[16+c];
                    2'd1: sel = (c != int'(cpu));
                    2'd2: sel = (c == int'(cpu));
                    default: sel = 1'b0;
                endcase
                if (sel) begin
                    setm[c*NS + int'(data[3:0])] = 1'b1;
                    if (c != int'(cpu)) ke[c] = 1'b1;
                end
            end
        end
        for (int c = 0; c < NC; c++)
            if (ce[c]) model[c*NS + int'(cid[c*4 +: 4])] = 1'b0;
        model = model | setm;
        @(posedge clk);
        #1;
        it.pend = model; it.kick = ke; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic raise(input logic [1:0] cpu, input logic [1:0] flt, input logic [7:0] lst,
                         input logic [3:0] id, input string tag);
        op(1'b1, 12'hF00, {6'b0, flt, lst, 12'h000, id}, cpu, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pend", 64'(pend), 64'd0);
        check("R1 reset kick", 64'(kick), 64'd0);

        raise(2'd0, 2'd0, 8'b0000_0110, 4'd5, "R2 list cpu1,cpu2");
        raise(2'd1, 2'd0, 8'b0000_0011, 4'd2, "R7 list incl writer");
        op(1'b0, 12'hF00, 32'h0, 2'd0, '0, '0, "R7 kick pulse ends");
        raise(2'd2, 2'd1, 8'b0000_0000, 4'd9, "R3 all but writer");
        raise(2'd3, 2'd2, 8'hFF, 4'd15, "R4 self only");
        raise(2'd1, 2'd3, 8'h0F, 4'd7, "R5 reserved filter");
        raise(2'd0, 2'd0, 8'hF0, 4'd3, "R6 high list bits");
        op(1'b1, 12'hF00, 32'hFC90_FFF1, 2'd0, '0, '0, "R6 junk bits");
        raise(2'd0, 2'd0, 8'b0000_0110, 4'd5, "R8 repeat raise");
        op(1'b0, 12'h000, 32'h0, 2'd0, 4'b0010, 16'h0050, "R9 clear cpu1 id5");
        op(1'b1, 12'hF00, {8'h00, 8'h01, 16'h0004}, 2'd2, 4'b0001, 16'h0004,
           "R10 set beats clear");
        op(1'b1, 12'hF04, {8'h00, 8'h0F, 16'h0008}, 2'd0, '0, '0, "R11 wrong offset");
        op(1'b0, 12'hF00, {8'h00, 8'h0F, 16'h0008}, 2'd0, '0, '0, "R11 no strobe");
        op(1'b0, 12'h000, 32'h0, 2'd0, 4'b1111, 16'hFFFF, "R9 clear id15 all");
        op(1'b0, 12'h000, 32'h0, 2'd0, '0, '0, "R7 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule